// File: doc/BRIEF.md
# Banked Register Window Controller

This block owns the control register of a serial vehicle-bus protocol peripheral of the variable-pulse-width kind. It also steers CPU register-bus accesses into a bank of thirty-six byte registers. There are four DMA pointer/counter registers and thirty-two message-filter registers. The CPU reaches them through a window of four addresses. A group-select field in the control register decides which group of four registers sits in that window. Group 0 is the DMA set. Groups 1 to 8 are the filter registers, four per group. Select values 9 to 15 map to no group.

The same control register holds two more bits. One is a DMA suspend select. When it is set, the peripheral's DMA requests are held off while the error flag or the arbitration-lost flag is raised. When it is clear, requests pass through untouched, whatever the interrupt state. The other bit is a local loopback select. It routes the internal transmit signal straight back to the internal receive input. In that mode the external transmit pin is parked at its passive level and the external receive pin is ignored. The symbol coder, the filter logic and the DMA engine sit outside and connect only through ports.

Bus decoding is combinational on the current register contents. A control-register write is captured at the clock edge, so it steers accesses from the next cycle on.

Top module: `bank_window_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 at address 0. Every banked register reads 0x00 through the window at addresses 4 to 7.
- R2: The control register at address 0 holds bit 5 = DMA suspend, bit 4 = loopback and bits 3:0 = group select. Bits 7:6 read as zero. A write takes effect from the next cycle.
- R3: With group select 0, window address 4+i (i = 0..3) reads and writes DMA register i, which drives byte i of dma_regs_o.
- R4: With group select g in 1..8, window address 4+i reads and writes filter register (g-1)*4+i, which drives byte (g-1)*4+i of filt_regs_o.
- R5: With group select 9 to 15, window reads return 0x00 and window writes change no banked register.
- R6: bus_rdata_o is 0x00 whenever bus_rd_i is low, and for addresses 1 to 3.
- R7: With DMA suspend clear, dma_req_o equals dma_req_i whatever the error and arbitration-lost flags are.
- R8: With DMA suspend set, dma_req_o is low while err_flag_i or arb_lost_i is high. It follows dma_req_i once both flags are low.
- R9: With loopback set, core_rx_o equals core_tx_i without inversion and pad_tx_o holds the passive level (default 0). pad_rx_i and rx_invert_i have no effect on core_rx_o.
- R10: With loopback clear, pad_tx_o equals core_tx_i and core_rx_o equals pad_rx_i XOR rx_invert_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 3 | Register address: 0 control, 4..7 window |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| dma_req_i | input | 1 | DMA request from the peripheral |
| err_flag_i | input | 1 | Peripheral error status flag |
| arb_lost_i | input | 1 | Arbitration-lost status flag |
| dma_req_o | output | 1 | Gated DMA request to the DMA engine |
| core_tx_i | input | 1 | Transmit signal from the symbol encoder |
| core_rx_o | output | 1 | Receive signal to the symbol decoder |
| pad_tx_o | output | 1 | External transmit pin |
| pad_rx_i | input | 1 | External receive pin |
| rx_invert_i | input | 1 | Input polarity control for the external receive path |
| dma_regs_o | output | 32 | DMA pointer/counter registers, byte i = register i |
| filt_regs_o | output | 256 | Filter registers, byte k = register k |

## Verification
The checker checks the combinational rules on every cycle. These are the DMA gate in both suspend settings, the loopback routing and passive transmit level, and zero reads from unmapped groups. It also checks that a control write lands on the next cycle and that writes to an unmapped group leave every banked register unchanged. Only the bench scenarios can show the address mapping itself. That means the right filter register moving for a given group and offset, readback through the window, and bits 7:6 reading zero. They also cover the reset contents of all registers seen through the bus.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef struct packed {
    logic       dma_susp;
    logic       loop_en;
    logic [3:0] grp_sel;
  } ctrl_t;
  localparam int CTRL_BITS = 6;
endpackage

// File: rtl/bwc_ctrl_reg.sv
module bwc_ctrl_reg
  import bwc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= ctrl_t'(wdata_i[CTRL_BITS-1:0]);
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/bwc_bank_file.sv
module bwc_bank_file #(
  parameter int DATA_W     = 8,
  parameter int NUM_GROUPS = 9,
  parameter int GRP_REGS   = 4,
  parameter int SEL_W      = 4,
  parameter int IDX_W      = 2,
  localparam int TOTAL     = NUM_GROUPS * GRP_REGS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [SEL_W-1:0]        sel_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [TOTAL*DATA_W-1:0] regs_o
);
  logic [DATA_W-1:0] regs_q [TOTAL];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar r = 0; r < GRP_REGS; r++) begin : g_reg
      localparam int K = g * GRP_REGS + r;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q[K] <= '0;
        else if (wr_en_i && sel_i == SEL_W'(g) && idx_i == IDX_W'(r))
          regs_q[K] <= wdata_i;
      end
      assign regs_o[K*DATA_W +: DATA_W] = regs_q[K];
    end
  end

  // unmapped select values fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < TOTAL; k++) begin
      if (sel_i == SEL_W'(k / GRP_REGS) && idx_i == IDX_W'(k % GRP_REGS))
        rdata_o = regs_q[k];
    end
  end
endmodule

// File: rtl/bwc_dma_gate.sv
module bwc_dma_gate (
  input  logic susp_i,
  input  logic err_i,
  input  logic arb_lost_i,
  input  logic req_i,
  output logic req_o
);
  logic hold;
  assign hold  = susp_i && (err_i || arb_lost_i);
  assign req_o = req_i && !hold;
endmodule

// File: rtl/bwc_line_steer.sv
module bwc_line_steer #(
  parameter logic TX_PASSIVE = 1'b0
) (
  input  logic loop_i,
  input  logic core_tx_i,
  input  logic pad_rx_i,
  input  logic rx_invert_i,
  output logic core_rx_o,
  output logic pad_tx_o
);
  always_comb begin
    if (loop_i) begin
      core_rx_o = core_tx_i;
      pad_tx_o  = TX_PASSIVE;
    end else begin
      core_rx_o = pad_rx_i ^ rx_invert_i;
      pad_tx_o  = core_tx_i;
    end
  end
endmodule

// File: rtl/bank_window_ctrl.sv
module bank_window_ctrl
  import bwc_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter int   ADDR_W     = 3,
  parameter int   NUM_GROUPS = 9,
  parameter int   GRP_REGS   = 4,
  parameter int   CTRL_ADDR  = 0,
  parameter int   WIN_BASE   = 4,
  parameter logic TX_PASSIVE = 1'b0,
  localparam int  IDX_W      = $clog2(GRP_REGS),
  localparam int  TOTAL      = NUM_GROUPS * GRP_REGS,
  localparam int  FILT_REGS  = TOTAL - GRP_REGS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic                        bus_wr_i,
  input  logic                        bus_rd_i,
  input  logic [DATA_W-1:0]           bus_wdata_i,
  output logic [DATA_W-1:0]           bus_rdata_o,
  input  logic                        dma_req_i,
  input  logic                        err_flag_i,
  input  logic                        arb_lost_i,
  output logic                        dma_req_o,
  input  logic                        core_tx_i,
  output logic                        core_rx_o,
  output logic                        pad_tx_o,
  input  logic                        pad_rx_i,
  input  logic                        rx_invert_i,
  output logic [GRP_REGS*DATA_W-1:0]  dma_regs_o,
  output logic [FILT_REGS*DATA_W-1:0] filt_regs_o
);
  ctrl_t                    ctrl_q;
  logic                     ctrl_hit, win_hit;
  logic [DATA_W-1:0]        win_rdata;
  logic [TOTAL*DATA_W-1:0]  bank_flat;
  logic [CTRL_BITS-1:0]     ctrl_bits;

  assign ctrl_hit  = bus_addr_i == ADDR_W'(CTRL_ADDR);
  assign win_hit   = bus_addr_i[ADDR_W-1:IDX_W] == ADDR_W'(WIN_BASE) >> IDX_W;
  assign ctrl_bits = ctrl_q;

  bwc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (bus_wr_i && ctrl_hit),
    .wdata_i (bus_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  bwc_bank_file #(
    .DATA_W(DATA_W), .NUM_GROUPS(NUM_GROUPS), .GRP_REGS(GRP_REGS),
    .SEL_W(4), .IDX_W(IDX_W)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (bus_wr_i && win_hit),
    .sel_i   (ctrl_q.grp_sel),
    .idx_i   (bus_addr_i[IDX_W-1:0]),
    .wdata_i (bus_wdata_i),
    .rdata_o (win_rdata),
    .regs_o  (bank_flat)
  );

  bwc_dma_gate u_gate (
    .susp_i     (ctrl_q.dma_susp),
    .err_i      (err_flag_i),
    .arb_lost_i (arb_lost_i),
    .req_i      (dma_req_i),
    .req_o      (dma_req_o)
  );

  bwc_line_steer #(.TX_PASSIVE(TX_PASSIVE)) u_steer (
    .loop_i      (ctrl_q.loop_en),
    .core_tx_i   (core_tx_i),
    .pad_rx_i    (pad_rx_i),
    .rx_invert_i (rx_invert_i),
    .core_rx_o   (core_rx_o),
    .pad_tx_o    (pad_tx_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i) begin
      if (ctrl_hit)     bus_rdata_o = DATA_W'(ctrl_bits);
      else if (win_hit) bus_rdata_o = win_rdata;
    end
  end

  assign dma_regs_o  = bank_flat[GRP_REGS*DATA_W-1:0];
  assign filt_regs_o = bank_flat[TOTAL*DATA_W-1:GRP_REGS*DATA_W];
endmodule

// File: rtl/bank_window_ctrl_chk.sv
module bank_window_ctrl_chk #(
  parameter int   DATA_W     = 8,
  parameter int   ADDR_W     = 3,
  parameter int   NUM_GROUPS = 9,
  parameter int   CTRL_ADDR  = 0,
  parameter int   WIN_BASE   = 4,
  parameter logic TX_PASSIVE = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              dma_req_i,
  input logic              err_flag_i,
  input logic              arb_lost_i,
  input logic              dma_req_o,
  input logic              core_tx_i,
  input logic              core_rx_o,
  input logic              pad_tx_o,
  input logic [5:0]        ctrl_bits,
  input logic              win_hit,
  input logic [TOTAL_W-1:0] bank_flat
);
  localparam int TOTAL_W = NUM_GROUPS * 4 * DATA_W;

  // R8
  susp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_bits[5] && (err_flag_i || arb_lost_i)) |-> !dma_req_o);

  // R7
  no_susp_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_bits[5] |-> dma_req_o == dma_req_i);

  // R9
  loop_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_bits[4] |-> (pad_tx_o == TX_PASSIVE && core_rx_o == core_tx_i));

  // R5
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && win_hit && ctrl_bits[3:0] >= 4'(NUM_GROUPS)) |-> bus_rdata_o == '0);

  // R5
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && win_hit && ctrl_bits[3:0] >= 4'(NUM_GROUPS)) |=> $stable(bank_flat));

  // R2
  ctrl_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(CTRL_ADDR)) |=> ctrl_bits == $past(bus_wdata_i[5:0]));

  // R6
  idle_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_i |-> bus_rdata_o == '0);
endmodule

bind bank_window_ctrl bank_window_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_GROUPS(NUM_GROUPS),
  .CTRL_ADDR(CTRL_ADDR), .WIN_BASE(WIN_BASE), .TX_PASSIVE(TX_PASSIVE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i),
  .bus_rd_i(bus_rd_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .dma_req_i(dma_req_i), .err_flag_i(err_flag_i), .arb_lost_i(arb_lost_i),
  .dma_req_o(dma_req_o), .core_tx_i(core_tx_i), .core_rx_o(core_rx_o),
  .pad_tx_o(pad_tx_o), .ctrl_bits(ctrl_bits), .win_hit(win_hit),
  .bank_flat(bank_flat)
);

// File: tb/bank_window_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_window_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   addr = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [7:0]   wdata = '0;
  logic [7:0]   rdata;
  logic         dreq = 1'b0, err = 1'b0, arb = 1'b0, dreq_o;
  logic         ctx = 1'b0, crx, ptx, prx = 1'b0, rinv = 1'b0;
  logic [31:0]  dma_regs;
  logic [255:0] filt_regs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  bank_window_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .dma_req_i(dreq), .err_flag_i(err),
    .arb_lost_i(arb), .dma_req_o(dreq_o), .core_tx_i(ctx), .core_rx_o(crx),
    .pad_tx_o(ptx), .pad_rx_i(prx), .rx_invert_i(rinv), .dma_regs_o(dma_regs),
    .filt_regs_o(filt_regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (rd && exp_q.size() > 0) begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(t, {24'h0, rdata}, {24'h0, e});
    end
  end

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    addr = a; rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset contents
    bus_read(3'd0, 8'h00, "R1 ctrl");
    for (int i = 0; i < 4; i++) bus_read(3'(4 + i), 8'h00, "R1 window");
    #1 chk("R1 filt", {31'h0, filt_regs == '0}, 32'h1);

    // R2 layout, bits 7:6 read zero
    bus_write(3'd0, 8'hFF);
    bus_read(3'd0, 8'h3F, "R2 readback");
    bus_write(3'd0, 8'h00);
    bus_read(3'd0, 8'h00, "R2 clear");

    // R3 DMA group
    for (int i = 0; i < 4; i++) bus_write(3'(4 + i), 8'hA0 + 8'(i));
    for (int i = 0; i < 4; i++) bus_read(3'(4 + i), 8'hA0 + 8'(i), "R3 window");
    #1 chk("R3 dma_regs", dma_regs, 32'hA3A2A1A0);

    // R4 filter groups
    bus_write(3'd0, 8'h03);
    bus_write(3'd6, 8'h5C);
    #1 chk("R4 filt 10", {24'h0, filt_regs[10*8 +: 8]}, 32'h5C);
    bus_read(3'd6, 8'h5C, "R4 readback");
    bus_write(3'd0, 8'h08);
    bus_write(3'd7, 8'hE7);
    #1 chk("R4 filt 31", {24'h0, filt_regs[31*8 +: 8]}, 32'hE7);
    bus_write(3'd0, 8'h01);
    bus_write(3'd4, 8'h3C);
    #1 chk("R4 filt 0", {24'h0, filt_regs[7:0]}, 32'h3C);
    chk("R4 dma untouched", dma_regs, 32'hA3A2A1A0);

    // R5 unmapped selects
    bus_write(3'd0, 8'h09);
    bus_write(3'd4, 8'h11);
    bus_read(3'd4, 8'h00, "R5 sel9 read");
    bus_write(3'd0, 8'h0F);
    bus_write(3'd5, 8'h22);
    bus_read(3'd5, 8'h00, "R5 sel15 read");
    #1 chk("R5 dma unchanged", dma_regs, 32'hA3A2A1A0);
    chk("R5 filt unchanged", {24'h0, filt_regs[10*8 +: 8]}, 32'h5C);
    chk("R5 filt0 unchanged", {24'h0, filt_regs[7:0]}, 32'h3C);

    // R6 no read strobe, unused address
    #1 addr = 3'd0;
    #2 chk("R6 rd low", {24'h0, rdata}, 32'h0);
    bus_read(3'd2, 8'h00, "R6 addr2");

    // R7 suspend clear
    bus_write(3'd0, 8'h00);
    dreq = 1'b1; err = 1'b1; arb = 1'b1;
    #2 chk("R7 pass with flags", {31'h0, dreq_o}, 32'h1);

    // R8 suspend set
    bus_write(3'd0, 8'h20);
    #2 chk("R8 both flags", {31'h0, dreq_o}, 32'h0);
    err = 1'b0;
    #2 chk("R8 arb only", {31'h0, dreq_o}, 32'h0);
    err = 1'b1; arb = 1'b0;
    #2 chk("R8 err only", {31'h0, dreq_o}, 32'h0);
    err = 1'b0;
    #2 chk("R8 resume", {31'h0, dreq_o}, 32'h1);
    dreq = 1'b0;
    #2 chk("R8 follow low", {31'h0, dreq_o}, 32'h0);

    // R10 normal routing
    bus_write(3'd0, 8'h00);
    ctx = 1'b1; prx = 1'b1; rinv = 1'b0;
    #2 chk("R10 pad_tx", {31'h0, ptx}, 32'h1);
    chk("R10 core_rx", {31'h0, crx}, 32'h1);
    rinv = 1'b1;
    #2 chk("R10 inverted rx", {31'h0, crx}, 32'h0);

    // R9 loopback
    bus_write(3'd0, 8'h10);
    ctx = 1'b1; prx = 1'b0; rinv = 1'b1;
    #2 chk("R9 loop rx", {31'h0, crx}, 32'h1);
    chk("R9 passive tx", {31'h0, ptx}, 32'h0);
    ctx = 1'b0; prx = 1'b1; rinv = 1'b0;
    #2 chk("R9 loop rx low", {31'h0, crx}, 32'h0);
    chk("R9 passive tx hold", {31'h0, ptx}, 32'h0);

    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) chk("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule